// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block builds the per-element enable mask for a vector operation of up to 64 elements. A caller raises `start` for one cycle with a mode, a 3-bit selector and a vector length. In integer mode the mask is taken from one of three scalar register values (r3, r10, r30): copied as is, inverted, set to all ones, or reduced to a single bit at a position given by r3. In condition mode the mask is built from a bank of 4-bit condition fields, one field per element. A chosen bit is taken from each field, optionally inverted, and stored as mask bit i for every element i below the vector length.

A small state machine sequences the work. Its states are ST_IDLE (waiting), ST_SCAN (one condition field per clock) and ST_DONE (result ready, `done` high). Its transitions are: IDLE to DONE on an integer start or on a condition start with length zero; IDLE to SCAN on a condition start with a nonzero length; SCAN to SCAN while fields remain; SCAN to DONE after the last field; DONE to IDLE always. The mask register holds its value until the next accepted start.

Top module: `pred_mask_gen`

## Requirements
- R1: While and after reset, `done` and `busy` are low and `mask` is all zeros.
- R2: In integer mode, selector 0 gives all ones, 2 gives r3, 3 gives ~r3, 4 gives r10, 5 gives ~r10, 6 gives r30 and 7 gives ~r30.
- R3: In integer mode, selector 1 gives a mask with exactly one bit set, at position r3[5:0].
- R4: Register and selector inputs are sampled at the clock edge that accepts `start`. Changing them afterwards does not alter the result.
- R5: In condition mode, field i is `cr_bank[4*i+3:4*i]`. Selector bits [2:1] pick the bit within the field and selector bit 0 inverts it: 0 bit0, 1 ~bit0, 2 bit1, 3 ~bit1, 4 bit2, 5 ~bit2, 6 bit3, 7 ~bit3. Mask bit i is that value.
- R6: In condition mode, mask bits at positions VL and above are zero.
- R7: `busy` is high for L cycles after the accepting edge, where L is 1 in integer mode and VL+1 in condition mode. `done` is high only in the last of those cycles.
- R8: A `vl` above 64 acts as 64. A condition start with `vl` of 0 yields an all-zero mask with L equal to 1.
- R9: `done` is a single-cycle pulse and is followed by `busy` low.
- R10: A `start` raised while `busy` is high is ignored. It changes neither the timing nor the mask.
- R11: Between operations, `mask` keeps its last result whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| cr_mode | input | 1 | 1 = condition-field mode, 0 = integer mode |
| sel | input | 3 | Selector code |
| vl | input | 7 | Vector length, 0..127, clamped to 64 |
| r3 | input | 64 | Scalar register r3 value |
| r10 | input | 64 | Scalar register r10 value |
| r30 | input | 64 | Scalar register r30 value |
| cr_bank | input | 256 | 64 condition fields of 4 bits, held stable during a scan |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-ready pulse |
| mask | output | 64 | Element enable mask |

## Verification
The bench aims at three groups of cases. The first is the length limits: VL of 0, 1, 64 and values above 64. A design that mishandled these would scan one field too many or too few, leave stale high bits, or wrap its index counter. The second is the unary selector at positions 0 and 63 and the inverted condition codes, where a wrong shift width or a dropped invert shows up as a misplaced or flipped mask bit. The third is a stray `start` during a scan and register values that change after acceptance. A design that restarted or sampled late would finish early or return a different mask.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DONE
    } scan_state_e;

    localparam logic [2:0] SEL_ALL   = 3'd0;
    localparam logic [2:0] SEL_UNARY = 3'd1;
    localparam logic [2:0] SEL_R3    = 3'd2;
    localparam logic [2:0] SEL_NR3   = 3'd3;
    localparam logic [2:0] SEL_R10   = 3'd4;
    localparam logic [2:0] SEL_NR10  = 3'd5;
    localparam logic [2:0] SEL_R30   = 3'd6;
    localparam logic [2:0] SEL_NR30  = 3'd7;
endpackage

// File: rtl/pmask_int_sel.sv
module pmask_int_sel
    import pmask_pkg::*;
#(
    parameter int LANES = 64
) (
    input  logic [2:0]       sel,
    input  logic [LANES-1:0] r3,
    input  logic [LANES-1:0] r10,
    input  logic [LANES-1:0] r30,
    output logic [LANES-1:0] int_mask
);
    localparam int IDXW = $clog2(LANES);

    always_comb begin
        unique case (sel)
            SEL_ALL:   int_mask = '1;
            SEL_UNARY: int_mask = LANES'(1) << r3[IDXW-1:0];
            SEL_R3:    int_mask = r3;
            SEL_NR3:   int_mask = ~r3;
            SEL_R10:   int_mask = r10;
            SEL_NR10:  int_mask = ~r10;
            SEL_R30:   int_mask = r30;
            SEL_NR30:  int_mask = ~r30;
            default:   int_mask = '0;
        endcase
    end
endmodule

// File: rtl/pmask_cr_pick.sv
module pmask_cr_pick #(
    parameter int FW = 4
) (
    input  logic [FW-1:0] field,
    input  logic [2:0]    code,
    output logic          bit_out
);
    logic chosen;

    always_comb begin
        chosen  = field[code[2:1]];
        bit_out = chosen ^ code[0];
    end
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen
    import pmask_pkg::*;
#(
    parameter int LANES = 64,
    parameter int FW    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      cr_mode,
    input  logic [2:0]                sel,
    input  logic [$clog2(LANES):0]    vl,
    input  logic [LANES-1:0]          r3,
    input  logic [LANES-1:0]          r10,
    input  logic [LANES-1:0]          r30,
    input  logic [LANES*FW-1:0]       cr_bank,
    output logic                      busy,
    output logic                      done,
    output logic [LANES-1:0]          mask
);
    localparam int IDXW = $clog2(LANES);
    localparam int VLW  = IDXW + 1;

    scan_state_e       state_q, state_d;
    logic [IDXW-1:0]   idx_q;
    logic [VLW-1:0]    last_q;
    logic [2:0]        code_q;
    logic [LANES-1:0]  mask_q;
    logic [LANES-1:0]  int_mask;
    logic [VLW-1:0]    vl_eff;
    logic [FW-1:0]     cur_field;
    logic              cur_bit;
    logic              accept;

    always_comb begin
        vl_eff    = (vl > VLW'(LANES)) ? VLW'(LANES) : vl;
        accept    = start && (state_q == ST_IDLE);
        cur_field = cr_bank[idx_q*FW +: FW];
    end

    pmask_int_sel #(.LANES(LANES)) u_int_sel (
        .sel      (sel),
        .r3       (r3),
        .r10      (r10),
        .r30      (r30),
        .int_mask (int_mask)
    );

    pmask_cr_pick #(.FW(FW)) u_cr_pick (
        .field   (cur_field),
        .code    (code_q),
        .bit_out (cur_bit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (cr_mode && (vl_eff != '0)) state_d = ST_SCAN;
                    else                           state_d = ST_DONE;
                end
            end
            ST_SCAN: begin
                if (VLW'(idx_q) == last_q) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            last_q <= '0;
            code_q <= '0;
            mask_q <= '0;
        end else if (accept) begin
            idx_q  <= '0;
            last_q <= vl_eff - VLW'(1);
            code_q <= sel;
            mask_q <= cr_mode ? '0 : int_mask;
        end else if (state_q == ST_SCAN) begin
            mask_q[idx_q] <= cur_bit;
            idx_q         <= idx_q + IDXW'(1);
        end
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
        mask = mask_q;
    end
endmodule

// File: rtl/pmask_chk.sv
module pmask_chk #(
    parameter int LANES = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   cr_mode,
    input logic [2:0]             sel,
    input logic [$clog2(LANES):0] vl,
    input logic                   busy,
    input logic                   done,
    input logic [LANES-1:0]       mask
);
    localparam int VLW = $clog2(LANES) + 1;

    logic           cr_sh;
    logic [VLW-1:0] vl_sh;
    logic [VLW:0]   cyc;
    logic           acc;

    always_comb acc = start && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_sh <= 1'b0;
            vl_sh <= '0;
            cyc   <= '0;
        end else if (acc) begin
            cr_sh <= cr_mode;
            vl_sh <= (vl > VLW'(LANES)) ? VLW'(LANES) : vl;
            cyc   <= (VLW+1)'(1);
        end else if (busy) begin
            cyc   <= cyc + (VLW+1)'(1);
        end
    end

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r2_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cr_mode && sel == 3'd0) |=> (done && mask == '1));

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cr_sh) |-> ((mask >> vl_sh) == '0));

    a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc == (cr_sh ? ((VLW+1)'(vl_sh) + (VLW+1)'(1)) : (VLW+1)'(1))));

    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cr_mode && vl == '0) |=> (done && mask == '0));

    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(mask));
endmodule

bind pred_mask_gen pmask_chk #(.LANES(LANES)) u_pmask_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .cr_mode (cr_mode),
    .sel     (sel),
    .vl      (vl),
    .busy    (busy),
    .done    (done),
    .mask    (mask)
);

// File: tb/test_pred_mask_gen.sv
module test_pred_mask_gen;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cr_mode = 1'b0;
    logic [2:0]   sel = '0;
    logic [6:0]   vl = '0;
    logic [63:0]  r3 = '0, r10 = '0, r30 = '0;
    logic [255:0] cr_bank = '0;
    logic         busy, done;
    logic [63:0]  mask;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    pred_mask_gen i_pred_mask_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .cr_mode(cr_mode),
        .sel(sel), .vl(vl), .r3(r3), .r10(r10), .r30(r30),
        .cr_bank(cr_bank), .busy(busy), .done(done), .mask(mask)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input bit crm, input logic [2:0] s, input int v,
                                          input logic [63:0] a3, input logic [63:0] a10,
                                          input logic [63:0] a30, input logic [255:0] b);
        logic [63:0] m = '0;
        int n;
        if (!crm) begin
            case (s)
                3'd0: m = {64{1'b1}};
                3'd1: m = 64'd1 << a3[5:0];
                3'd2: m = a3;
                3'd3: m = ~a3;
                3'd4: m = a10;
                3'd5: m = ~a10;
                3'd6: m = a30;
                default: m = ~a30;
            endcase
        end else begin
            n = (v > 64) ? 64 : v;
            for (int i = 0; i < n; i++) m[i] = b[4*i + int'(s[2:1])] ^ s[0];
        end
        return m;
    endfunction

    task automatic run_op(input bit crm, input logic [2:0] s, input logic [6:0] v,
                          input logic [63:0] a3, input logic [63:0] a10, input logic [63:0] a30,
                          input logic [255:0] b, input bit inject, input string req);
        logic [63:0] exp_m;
        int exp_l, cnt, n;
        n = (int'(v) > 64) ? 64 : int'(v);
        exp_m = model(crm, s, int'(v), a3, a10, a30, b);
        exp_l = crm ? n + 1 : 1;
        @(negedge clk);
        cr_mode = crm; sel = s; vl = v; r3 = a3; r10 = a10; r30 = a30; cr_bank = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R4: disturb sampled inputs after acceptance
        r3 = ~a3; r10 = ~a10; r30 = ~a30; sel = ~s; vl = ~v; cr_mode = ~crm;
        cnt = 1;
        while (!done && cnt < 200) begin
            start = (inject && cnt == 2);
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == exp_l, {req, " R7 latency"}, 64'(cnt), 64'(exp_l));
        chk(mask == exp_m, {req, " mask"}, mask, exp_m);
        @(negedge clk);
        chk(!done && !busy, "R9 done pulse", {62'd0, done, busy}, 64'd0);
        // R11: mask holds while idle
        r3 = {$urandom, $urandom}; sel = 3'($urandom);
        repeat (2) @(negedge clk);
        chk(mask == exp_m, "R11 hold", mask, exp_m);
    endtask

    function automatic logic [255:0] rbank();
        logic [255:0] b;
        for (int i = 0; i < 8; i++) b[32*i +: 32] = $urandom;
        return b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] b;
        logic [63:0] x, y, z;
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        chk(!done && !busy && mask == '0, "R1 in reset", mask, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && mask == '0, "R1 after reset", mask, 64'd0);

        x = 64'h0123_4567_89ab_cdef; y = 64'hfedc_ba98_7654_3210; z = 64'h0f0f_00ff_f0f0_ff00;
        for (int s = 0; s < 8; s++) run_op(1'b0, 3'(s), 7'd5, x, y, z, '0, 1'b0, "R2/R3 int code");
        run_op(1'b0, 3'd1, 7'd0, 64'h40, '0, '0, '0, 1'b0, "R3 unary pos 0");
        run_op(1'b0, 3'd1, 7'd0, 64'hffff_ffff_ffff_ff3f, '0, '0, '0, 1'b0, "R3 unary pos 63");

        b = rbank();
        for (int s = 0; s < 8; s++) run_op(1'b1, 3'(s), 7'd64, '0, '0, '0, b, 1'b0, "R5 cr code");
        run_op(1'b1, 3'd6, 7'd1, '0, '0, '0, '1, 1'b0, "R6 vl=1");
        run_op(1'b1, 3'd1, 7'd17, '0, '0, '0, '0, 1'b0, "R6 inverted vl=17");
        run_op(1'b1, 3'd3, 7'd0, '0, '0, '0, '0, 1'b0, "R8 vl=0");
        run_op(1'b1, 3'd4, 7'd100, '0, '0, '0, b, 1'b0, "R8 vl clamp");
        run_op(1'b1, 3'd2, 7'd20, '0, '0, '0, b, 1'b1, "R10 start ignored");

        for (int k = 0; k < 300; k++) begin
            run_op(1'($urandom), 3'($urandom), 7'($urandom), {$urandom, $urandom},
                   {$urandom, $urandom}, {$urandom, $urandom}, rbank(),
                   1'($urandom), "R2/R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule